// File: doc/BRIEF.md
# Head Recalibrate Step Sequencer

This block carries out the recalibrate control command of a floppy disk controller. It returns the read/write head to the outermost cylinder. Once a start strobe is accepted, it clears the present cylinder number and holds the direction output at the outward value. It then issues one step pulse per step-rate tick for as long as the track-zero sense input stays low.

When the synchronized sense input is high at a decision tick, the command ends normally. If the step budget runs out first, the command ends as a failure. In both cases the block latches a status byte and raises an interrupt request. No result bytes are produced and no data moves. The status stays latched until the host issues a sense-interrupt-status read strobe. That strobe clears the interrupt, clears the latch, and presents the captured status byte and cylinder value on read-back outputs.

The command-byte parser, the seek command, the host register file and the data path sit outside this block.

Top module: `fdc_recal_seq`

## Requirements
- R1: After reset, busy_o, irq_o and step_o are 0, dir_o is 1, and st0_o, pcn_o, rd_st0_o and rd_pcn_o are all zero.
- R2: A start_i strobe seen while idle makes busy_o 1, dir_o 0 and pcn_o 0 from the following cycle.
- R3: While busy, a tick that finds the head away from track zero raises step_o, and the next tick lowers it, so each pulse lasts exactly one tick period. step_o is never high while busy_o is 0.
- R4: trk_sense_i passes through a two-flop synchronizer. If the synchronized value is 1 at a decision tick (a tick with step_o low), the command ends normally with st0_o = 8'h20. In st0_o, bits 7:6 are the completion code (00 normal, 01 abnormal), bit 5 is seek-end and bit 4 is equipment-check. The other bits are 0.
- R5: If MAX_STEPS (default 80) pulses have been issued and a decision tick still finds the sense low, the command ends abnormally with st0_o = 8'h70, after exactly MAX_STEPS pulses.
- R6: On completion, busy_o falls and irq_o rises on the same clock edge.
- R7: A sense_rd_i strobe while idle clears irq_o and st0_o on the next cycle, and loads rd_st0_o and rd_pcn_o with the status byte and cylinder value held before the strobe.
- R8: A start_i strobe while busy_o is 1 is ignored: the pulse count and the final status are those of the command already running.
- R9: If the sense input is already high when the command starts, the command ends at the first decision tick with no step pulse and st0_o = 8'h20.
- R10: dir_o stays 0 for the whole time busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle command start strobe |
| trk_sense_i | input | 1 | Track-zero sense from the drive, asynchronous; 1 ends stepping |
| step_tick_i | input | 1 | Single-cycle step-rate tick |
| sense_rd_i | input | 1 | Single-cycle sense-interrupt-status read strobe |
| dir_o | output | 1 | Step direction to the drive, 0 = outward |
| step_o | output | 1 | Step pulse to the drive |
| busy_o | output | 1 | Command in progress |
| irq_o | output | 1 | Interrupt request, held until a sense read |
| pcn_o | output | PCN_W | Present cylinder number |
| st0_o | output | 8 | Latched status register 0 byte |
| rd_st0_o | output | 8 | Status byte captured by the last sense read |
| rd_pcn_o | output | PCN_W | Cylinder value captured by the last sense read |

## Verification
The assertions assume that start_i, sense_rd_i and step_tick_i are single-cycle strobes. They also assume a sense read arrives only while the block is idle, since a read that coincides with completion is not constrained. The stimulus drives every strobe for exactly one cycle at the falling edge and issues ticks on a fixed four-cycle period. A drive model counts step pulses and raises the track-zero sense after a chosen count. Sense reads are held back until the interrupt has been seen with busy low.

// File: rtl/fdc_recal_pkg.sv
package fdc_recal_pkg;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'd0,
    RC_WAIT  = 2'd1,
    RC_PULSE = 2'd2
  } rc_state_e;

  // status byte layout: completion code, seek-end, equipment-check, spare
  typedef struct packed {
    logic [1:0] ic;
    logic       se;
    logic       ec;
    logic [3:0] spare;
  } st0_t;

  localparam logic [1:0] IC_NORMAL   = 2'b00;
  localparam logic [1:0] IC_ABNORMAL = 2'b01;

endpackage

// File: rtl/fdc_bit_sync.sv
module fdc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/fdc_recal_ctrl.sv
module fdc_recal_ctrl
  import fdc_recal_pkg::*;
#(
  parameter int MAX_STEPS = 80,
  parameter int PCN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trk_s_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             step_o,
  output logic             dir_o,
  output logic [PCN_W-1:0] pcn_o,
  output logic             done_ok_o,
  output logic             done_fail_o
);

  localparam int CNT_W = $clog2(MAX_STEPS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_STEPS);

  rc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_q, step_d;
  logic             dir_q, dir_d;
  logic [PCN_W-1:0] pcn_q, pcn_d;
  logic             en;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    step_d      = step_q;
    dir_d       = dir_q;
    pcn_d       = pcn_q;
    done_ok_o   = 1'b0;
    done_fail_o = 1'b0;
    unique case (state_q)
      RC_IDLE: begin
        if (start_i) begin
          state_d = RC_WAIT;
          cnt_d   = '0;
          dir_d   = 1'b0;
          pcn_d   = '0;
        end
      end
      RC_WAIT: begin
        if (tick_i) begin
          if (trk_s_i) begin
            done_ok_o = 1'b1;
            state_d   = RC_IDLE;
          end else if (cnt_q == CNT_LAST) begin
            done_fail_o = 1'b1;
            state_d     = RC_IDLE;
          end else begin
            step_d  = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            state_d = RC_PULSE;
          end
        end
      end
      RC_PULSE: begin
        if (tick_i) begin
          step_d  = 1'b0;
          state_d = RC_WAIT;
        end
      end
      default: state_d = RC_IDLE;
    endcase
  end

  // registers load only when the state machine has something to do
  assign en = (state_q == RC_IDLE) ? start_i : tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      cnt_q   <= '0;
      step_q  <= 1'b0;
      dir_q   <= 1'b1;
      pcn_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      step_q  <= step_d;
      dir_q   <= dir_d;
      pcn_q   <= pcn_d;
    end
  end

  assign busy_o = (state_q != RC_IDLE);
  assign step_o = step_q;
  assign dir_o  = dir_q;
  assign pcn_o  = pcn_q;

endmodule

// File: rtl/fdc_recal_status.sv
module fdc_recal_status
  import fdc_recal_pkg::*;
#(
  parameter int PCN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_ok_i,
  input  logic             done_fail_i,
  input  logic             sense_rd_i,
  input  logic [PCN_W-1:0] pcn_i,
  output logic [7:0]       st0_o,
  output logic             irq_o,
  output logic [7:0]       rd_st0_o,
  output logic [PCN_W-1:0] rd_pcn_o
);

  st0_t             st0_q, st0_d;
  logic             irq_q, irq_d;
  logic [7:0]       rd_st0_q, rd_st0_d;
  logic [PCN_W-1:0] rd_pcn_q, rd_pcn_d;
  logic             done;

  assign done = done_ok_i | done_fail_i;

  always_comb begin
    st0_d    = st0_q;
    irq_d    = irq_q;
    rd_st0_d = rd_st0_q;
    rd_pcn_d = rd_pcn_q;
    if (sense_rd_i) begin
      rd_st0_d = st0_q;
      rd_pcn_d = pcn_i;
      st0_d    = '0;
      irq_d    = 1'b0;
    end
    if (done) begin
      st0_d.ic    = done_fail_i ? IC_ABNORMAL : IC_NORMAL;
      st0_d.se    = 1'b1;
      st0_d.ec    = done_fail_i;
      st0_d.spare = '0;
      irq_d       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0_q    <= '0;
      irq_q    <= 1'b0;
      rd_st0_q <= '0;
      rd_pcn_q <= '0;
    end else if (done | sense_rd_i) begin
      st0_q    <= st0_d;
      irq_q    <= irq_d;
      rd_st0_q <= rd_st0_d;
      rd_pcn_q <= rd_pcn_d;
    end
  end

  assign st0_o    = st0_q;
  assign irq_o    = irq_q;
  assign rd_st0_o = rd_st0_q;
  assign rd_pcn_o = rd_pcn_q;

endmodule

// File: rtl/fdc_recal_seq.sv
module fdc_recal_seq #(
  parameter int MAX_STEPS = 80,
  parameter int PCN_W     = 8,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trk_sense_i,
  input  logic             step_tick_i,
  input  logic             sense_rd_i,
  output logic             dir_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic [PCN_W-1:0] pcn_o,
  output logic [7:0]       st0_o,
  output logic [7:0]       rd_st0_o,
  output logic [PCN_W-1:0] rd_pcn_o
);

  logic [1:0] rst_sh_q;
  logic       rst_int_n;
  logic       trk_s;
  logic       done_ok;
  logic       done_fail;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  fdc_bit_sync #(.STAGES(SYNC_N)) u_trk_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (trk_sense_i),
    .q_o   (trk_s)
  );

  fdc_recal_ctrl #(.MAX_STEPS(MAX_STEPS), .PCN_W(PCN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .trk_s_i     (trk_s),
    .tick_i      (step_tick_i),
    .busy_o      (busy_o),
    .step_o      (step_o),
    .dir_o       (dir_o),
    .pcn_o       (pcn_o),
    .done_ok_o   (done_ok),
    .done_fail_o (done_fail)
  );

  fdc_recal_status #(.PCN_W(PCN_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .done_ok_i   (done_ok),
    .done_fail_i (done_fail),
    .sense_rd_i  (sense_rd_i),
    .pcn_i       (pcn_o),
    .st0_o       (st0_o),
    .irq_o       (irq_o),
    .rd_st0_o    (rd_st0_o),
    .rd_pcn_o    (rd_pcn_o)
  );

endmodule

module fdc_recal_seq_chk #(
  parameter int PCN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             step_tick_i,
  input logic             sense_rd_i,
  input logic             dir_o,
  input logic             step_o,
  input logic             busy_o,
  input logic             irq_o,
  input logic [PCN_W-1:0] pcn_o,
  input logic [7:0]       st0_o
);

  a_r3_step_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> busy_o);

  a_r3_step_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_o) |-> $past(step_tick_i));

  a_r2_pcn_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (pcn_o == '0));

  a_r6_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> irq_o);

  a_r4_seek_end_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> st0_o[5]);

  a_r7_sense_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_rd_i && !busy_o) |=> !irq_o);

  a_r10_dir_out_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !dir_o);

  a_r8_start_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !step_tick_i) |=> (busy_o && $stable(step_o)));

endmodule

bind fdc_recal_seq fdc_recal_seq_chk #(.PCN_W(PCN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .step_tick_i (step_tick_i),
  .sense_rd_i  (sense_rd_i),
  .dir_o       (dir_o),
  .step_o      (step_o),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .pcn_o       (pcn_o),
  .st0_o       (st0_o)
);

// File: tb/fdc_recal_seq_bench.sv
module fdc_recal_seq_bench;

  localparam int PCN_W  = 8;
  localparam int MAXS   = 80;
  localparam int TICK_P = 4;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic             trk_sense_i;
  logic             step_tick_i;
  logic             sense_rd_i;
  logic             dir_o;
  logic             step_o;
  logic             busy_o;
  logic             irq_o;
  logic [PCN_W-1:0] pcn_o;
  logic [7:0]       st0_o;
  logic [7:0]       rd_st0_o;
  logic [PCN_W-1:0] rd_pcn_o;

  typedef struct {
    logic [7:0] st0;
    int         pulses;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_fails;
  int   target;
  bit   finished;

  fdc_recal_seq #(.MAX_STEPS(MAXS), .PCN_W(PCN_W)) u_fdc_recal_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .trk_sense_i (trk_sense_i),
    .step_tick_i (step_tick_i),
    .sense_rd_i  (sense_rd_i),
    .dir_o       (dir_o),
    .step_o      (step_o),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .pcn_o       (pcn_o),
    .st0_o       (st0_o),
    .rd_st0_o    (rd_st0_o),
    .rd_pcn_o    (rd_pcn_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  // step-rate tick generator: one-cycle pulse every TICK_P cycles
  initial begin
    step_tick_i = 1'b0;
    forever begin
      repeat (TICK_P - 1) @(negedge clk);
      step_tick_i = 1'b1;
      @(negedge clk);
      step_tick_i = 1'b0;
    end
  end

  // drive model and scoreboard monitor
  initial begin
    int  pulses;
    int  width;
    bit  prev_step;
    bit  prev_busy;
    bit  dir_bad;
    bit  stray_step;
    exp_t e;
    pulses = 0; width = 0; prev_step = 0; prev_busy = 0; dir_bad = 0; stray_step = 0;
    trk_sense_i = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (step_o && !prev_step) pulses++;
        if (step_o) width++;
        if (!step_o && prev_step) begin
          chk(width == TICK_P, "R3 pulse width", width, TICK_P);
          width = 0;
        end
        if (step_o && !busy_o) stray_step = 1'b1;
        if (busy_o && dir_o) dir_bad = 1'b1;
        if (busy_o && !prev_busy) begin
          pulses = 0; dir_bad = 0;
        end
        if (!busy_o && prev_busy) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected completion", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(st0_o == e.st0, "R4/R5 status byte", st0_o, e.st0);
            chk(pulses == e.pulses, "R3/R5/R8/R9 pulse count", pulses, e.pulses);
            chk(irq_o == 1'b1, "R6 irq with busy fall", irq_o, 1);
            chk(pcn_o == '0, "R2 cylinder cleared", pcn_o, 0);
            chk(!dir_bad, "R10 dir low while busy", dir_bad, 0);
            chk(!stray_step, "R3 no step while idle", stray_step, 0);
          end
          pulses = 0;
        end
        prev_step = step_o;
        prev_busy = busy_o;
      end
      trk_sense_i = (pulses >= target);
    end
  end

  task automatic run_cmd(input int tgt, input logic [7:0] est0, input int epulses,
                         input bit restart);
    exp_t e;
    e.st0 = est0;
    e.pulses = epulses;
    exp_q.push_back(e);
    target = tgt;
    repeat (6) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(dir_o == 1'b0, "R2 dir outward", dir_o, 0);
    chk(pcn_o == '0, "R2 cylinder zero", pcn_o, 0);
    if (restart) begin
      repeat (21) @(negedge clk);
      start_i = 1'b1;   // R8: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(irq_o == 1'b1, "R7 irq held before read", irq_o, 1);
    sense_rd_i = 1'b1;
    @(negedge clk);
    sense_rd_i = 1'b0;
    chk(irq_o == 1'b0, "R7 irq cleared", irq_o, 0);
    chk(rd_st0_o == est0, "R7 read-back status", rd_st0_o, est0);
    chk(rd_pcn_o == '0, "R7 read-back cylinder", rd_pcn_o, 0);
    chk(st0_o == 8'h00, "R7 status latch cleared", st0_o, 0);
    chk(exp_q.size() == 0, "R6 completion seen", exp_q.size(), 0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 1'b0; target = 0;
    rst_n = 1'b0; start_i = 1'b0; sense_rd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0 && irq_o == 1'b0 && step_o == 1'b0, "R1 idle flags",
        {busy_o, irq_o, step_o}, 0);
    chk(dir_o == 1'b1, "R1 dir reset", dir_o, 1);
    chk(st0_o == 8'h00 && pcn_o == '0, "R1 status and cylinder", st0_o, 0);
    chk(rd_st0_o == 8'h00 && rd_pcn_o == '0, "R1 read-back zero", rd_st0_o, 0);

    run_cmd(0,   8'h20, 0,    1'b0);  // R9 already at track zero
    run_cmd(3,   8'h20, 3,    1'b0);  // R4
    run_cmd(17,  8'h20, 17,   1'b0);  // R4
    run_cmd(MAXS, 8'h20, MAXS, 1'b0); // R4 sense wins on the last decision
    run_cmd(200, 8'h70, MAXS, 1'b1);  // R5 budget exhausted, R8 restart ignored
    run_cmd(1,   8'h20, 1,    1'b0);  // R4 single step after a failure

    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule